// File: doc/BRIEF.md
# Packet length framing checker

This block watches a 64-bit transmit stream of transaction-layer packets on the side of the bus, without taking part in it. On each beat that opens a packet it decodes the first header dword. From that dword it learns the header size, whether a payload follows and how many payload dwords there are. From these it works out how many beats the packet must fill. It then counts the valid beats up to the end marker. A packet whose beat count does not match would stall a downstream transmitter, so every mismatch is reported.

Four kinds of framing fault raise a one-cycle pulse on the clock edge after the beat that shows them. The faults are a packet that ends too early, a packet that runs past its expected length, an opening marker inside an open packet, and a closing marker with no packet open. A sticky flag collects all faults until software-independent logic clears it with a clear input. The block never alters, drops or back-pressures the stream.

Top module: `pkt_len_chk`

## Requirements
- R1: On a valid start beat the payload length is in_data[9:0]; the value 0 stands for 1024 dwords.
- R2: in_data[29] set selects a 4-dword header and in_data[30] set marks a payload as present. A message packet has in_data[28:27] = 2'b10. It is framed with a 4-dword header whatever in_data[29] holds.
- R3: The expected beat count is (header dwords + payload dwords) divided by 2, rounded up. A packet whose valid beats, start to end inclusive, equal that count raises no pulse.
- R4: When the end beat arrives before the expected count is reached, len_err pulses high for one cycle on the edge after that end beat.
- R5: When a packet has no end marker by the time its valid beat count goes past the expected count, len_err pulses once. The pulse comes on the edge after the first beat past the count. Later beats of that packet, including its end beat, raise no further len_err.
- R6: A valid start beat while a packet is open pulses sop_err on the following edge. The open packet is abandoned without a length pulse, and tracking restarts from the new start beat.
- R7: A valid end beat with no start while no packet is open pulses eop_err on the following edge.
- R8: Beats with in_valid low are ignored whatever in_sop, in_eop and in_data hold. They raise no pulse and do not advance the beat count.
- R9: A beat carrying both start and end is a complete packet. It raises len_err unless the expected count is 1, which at this width never happens (the minimum is 2).
- R10: err_sticky rises together with any pulse and stays high until a cycle in which sticky_clr is high and no new fault is seen. A fault in the same cycle as the clear wins.
- R11: While rst_n is low and after its release, all outputs are low and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier of the watched stream |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 64 | Beat data; header dword 0 in bits 31:0 of the start beat |
| sticky_clr | input | 1 | Clears the sticky fault flag |
| len_err | output | 1 | One-cycle pulse: beat count differs from header |
| sop_err | output | 1 | One-cycle pulse: start beat inside open packet |
| eop_err | output | 1 | One-cycle pulse: end beat with no open packet |
| err_sticky | output | 1 | Accumulated fault flag |

## Verification
A wrong open-packet flag shows up on the very next marker. A spurious sop_err or eop_err appears, or a missing one, on the edge after that beat. A wrong count or wrong stored expectation shows up as a len_err pulse that is missing, doubled or early. The packets are sized so that header size, message framing, payload presence and the zero-length encoding each shift the expected count by at least one beat. A wrong decode therefore moves or creates a pulse by the end of the packet.

// File: rtl/pkt_len_chk_pkg.sv
package pkt_len_chk_pkg;
   localparam int LEN_W      = 10;
   localparam int MAX_LEN    = 1 << LEN_W;
   localparam int FMT_4DW_B  = 29;
   localparam int FMT_DATA_B = 30;
   localparam int TYPE_HI_B  = 28;
   localparam int TYPE_LO_B  = 27;
   localparam logic [1:0] MSG_CODE = 2'b10;

   typedef struct packed {
      logic len;
      logic sop;
      logic eop;
   } fault_t;
endpackage

// File: rtl/pkt_hdr_decode.sv
module pkt_hdr_decode
   import pkt_len_chk_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 10
) (
   input  logic [31:0]      hdr_dw0,
   output logic [CNT_W-1:0] exp_beats
);
   localparam int DW_PER_BEAT = DATA_W / 32;
   localparam int SHIFT       = $clog2(DW_PER_BEAT);
   localparam int TOT_W       = $clog2(MAX_LEN + 8);

   logic              four_dw;
   logic              has_pay;
   logic [TOT_W-1:0]  pay_dw;
   logic [TOT_W-1:0]  hdr_dw;
   logic [TOT_W-1:0]  tot_dw;
   logic [TOT_W-1:0]  beats_w;

   always_comb begin
      four_dw = hdr_dw0[FMT_4DW_B] ||
                (hdr_dw0[TYPE_HI_B:TYPE_LO_B] == MSG_CODE);
      has_pay = hdr_dw0[FMT_DATA_B];
      hdr_dw  = four_dw ? TOT_W'(4) : TOT_W'(3);
      if (!has_pay)
         pay_dw = '0;
      else if (hdr_dw0[LEN_W-1:0] == '0)
         pay_dw = TOT_W'(MAX_LEN);
      else
         pay_dw = TOT_W'(hdr_dw0[LEN_W-1:0]);
      tot_dw = hdr_dw + pay_dw;
   end

   generate
      if (SHIFT == 0) begin : g_one_dw
         assign beats_w = tot_dw;
      end else begin : g_multi_dw
         assign beats_w = (tot_dw + TOT_W'(DW_PER_BEAT - 1)) >> SHIFT;
      end
   endgenerate

   assign exp_beats = CNT_W'(beats_w);

   always_comb begin
      AST_EXP_NONZERO: assert (exp_beats != '0); // R3
   end
endmodule

// File: rtl/pkt_beat_track.sv
module pkt_beat_track
   import pkt_len_chk_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [CNT_W-1:0] new_exp,
   output fault_t           fault
);
   logic             open_q, open_n;
   logic             ovr_q, ovr_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0] exp_q, exp_n;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      open_n = open_q;
      ovr_n  = ovr_q;
      cnt_n  = cnt_q;
      exp_n  = exp_q;
      fault  = '0;
      nxt    = cnt_q + CNT_W'(1);
      if (in_valid) begin
         if (in_sop) begin
            fault.sop = open_q;
            if (in_eop) begin
               fault.len = (new_exp != CNT_W'(1));
               open_n    = 1'b0;
            end else begin
               open_n = 1'b1;
               cnt_n  = CNT_W'(1);
               exp_n  = new_exp;
               ovr_n  = 1'b0;
            end
         end else if (open_q) begin
            if (!ovr_q && (nxt > exp_q)) begin
               fault.len = 1'b1;
               ovr_n     = 1'b1;
            end
            if (!ovr_q)
               cnt_n = nxt;
            if (in_eop) begin
               if (nxt < exp_q)
                  fault.len = 1'b1;
               open_n = 1'b0;
            end
         end else if (in_eop) begin
            fault.eop = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         ovr_q  <= 1'b0;
         cnt_q  <= '0;
         exp_q  <= '0;
      end else begin
         open_q <= open_n;
         ovr_q  <= ovr_n;
         cnt_q  <= cnt_n;
         exp_q  <= exp_n;
      end
   end

   AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (cnt_q <= exp_q + CNT_W'(1))); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (fault == '0)); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(cnt_q) && $stable(open_q))); // R8
   AST_OVR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && ovr_q && !in_sop) |-> !fault.len); // R5
endmodule

// File: rtl/pkt_err_report.sv
module pkt_err_report
   import pkt_len_chk_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  fault_t fault,
   input  logic   sticky_clr,
   output logic   len_err,
   output logic   sop_err,
   output logic   eop_err,
   output logic   err_sticky
);
   logic any_fault;
   assign any_fault = |fault;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_err    <= 1'b0;
         sop_err    <= 1'b0;
         eop_err    <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         len_err <= fault.len;
         sop_err <= fault.sop;
         eop_err <= fault.eop;
         if (any_fault)
            err_sticky <= 1'b1;
         else if (sticky_clr)
            err_sticky <= 1'b0;
      end
   end

   AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (len_err || sop_err || eop_err) |-> err_sticky); // R10
   AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_clr && !any_fault) |=> !err_sticky); // R10
   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !sticky_clr) |=> err_sticky); // R10
endmodule

// File: rtl/pkt_len_chk.sv
module pkt_len_chk
   import pkt_len_chk_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              sticky_clr,
   output logic              len_err,
   output logic              sop_err,
   output logic              eop_err,
   output logic              err_sticky
);
   localparam int MAX_BEATS = (MAX_LEN + 4 + (DATA_W / 32) - 1) / (DATA_W / 32);
   localparam int CNT_W     = $clog2(MAX_BEATS + 2);

   initial begin : elab_chk
      if (DATA_W != 64)
         $fatal(1, "pkt_len_chk: only a 64-bit beat is implemented");
   end

   logic [CNT_W-1:0] new_exp;
   fault_t           fault;

   pkt_hdr_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dec_i (
      .hdr_dw0   (in_data[31:0]),
      .exp_beats (new_exp)
   );

   pkt_beat_track #(.CNT_W(CNT_W)) trk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .new_exp  (new_exp),
      .fault    (fault)
   );

   pkt_err_report rep_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault      (fault),
      .sticky_clr (sticky_clr),
      .len_err    (len_err),
      .sop_err    (sop_err),
      .eop_err    (eop_err),
      .err_sticky (err_sticky)
   );

   AST_EOP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      eop_err |-> $past(in_valid && in_eop && !in_sop)); // R7
   AST_SOP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      sop_err |-> $past(in_valid && in_sop)); // R6
   AST_LEN_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> $past(in_valid)); // R4
endmodule

// File: tb/pkt_len_chk_tb_top.sv
module pkt_len_chk_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic [63:0] in_data = '0;
   logic        sticky_clr = 1'b0;
   logic        len_err, sop_err, eop_err, err_sticky;

   int total = 0;
   int bad   = 0;
   int n_len, first_len, n_sop, n_eop;

   always #2 clk = ~clk;

   pkt_len_chk dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .sticky_clr(sticky_clr),
      .len_err(len_err), .sop_err(sop_err), .eop_err(eop_err),
      .err_sticky(err_sticky)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_beats(input logic [31:0] dw0);
      int hdr, pay;
      hdr = (dw0[29] || dw0[28:27] == 2'b10) ? 4 : 3;
      pay = dw0[30] ? ((dw0[9:0] == 0) ? 1024 : int'(dw0[9:0])) : 0;
      return (hdr + pay + 1) / 2;
   endfunction

   task automatic beat(input logic v, input logic s, input logic e,
                       input logic [63:0] d, input int idx);
      in_valid = v; in_sop = s; in_eop = e; in_data = d;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      if (len_err) begin
         n_len++;
         if (first_len < 0) first_len = idx;
      end
      if (sop_err) n_sop++;
      if (eop_err) n_eop++;
   endtask

   task automatic clr_tally();
      n_len = 0; n_sop = 0; n_eop = 0; first_len = -1;
   endtask

   task automatic send_pkt(input logic [31:0] dw0, input int n, input bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 2 == 1))
            beat(1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, -1);
         beat(1'b1, i == 0, i == n - 1,
              (i == 0) ? {32'hA5A5_0000, dw0} : {32'(i), 32'h1234_5678}, i);
      end
   endtask

   task automatic do_clear();
      sticky_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sticky_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R11 len_err in reset", int'(len_err), 0);
      check("R11 sticky in reset", int'(err_sticky), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 outputs after reset",
            int'({len_err, sop_err, eop_err, err_sticky}), 0);
   endtask

   task automatic t_good(input logic [31:0] dw0, input int want, input string req);
      check({req, " expected beats"}, exp_beats(dw0), want);
      clr_tally();
      send_pkt(dw0, want, 1'b0);
      check({req, " no pulse on good packet"}, n_len + n_sop + n_eop, 0);
      check({req, " sticky stays low"}, int'(err_sticky), 0);
   endtask

   task automatic t_early();
      clr_tally();
      send_pkt(32'h4000_0002, 2, 1'b0);
      check("R4 early end len pulses", n_len, 1);
      check("R4 pulse on end beat", first_len, 1);
      do_clear();
   endtask

   task automatic t_late();
      clr_tally();
      send_pkt(32'h4000_0001, 5, 1'b0);
      check("R5 overrun pulses once", n_len, 1);
      check("R5 pulse on first extra beat", first_len, 2);
      do_clear();
   endtask

   task automatic t_sop_inside();
      clr_tally();
      beat(1'b1, 1'b1, 1'b0, {32'h0, 32'h4000_0002}, 0);
      beat(1'b1, 1'b0, 1'b0, 64'h0, 1);
      send_pkt(32'h0000_0000, 2, 1'b0);
      check("R6 sop inside pulses", n_sop, 1);
      check("R6 restart gives no len pulse", n_len, 0);
      do_clear();
   endtask

   task automatic t_eop_out();
      clr_tally();
      beat(1'b1, 1'b0, 1'b1, 64'h0, 0);
      check("R7 lone end pulses", n_eop, 1);
      check("R7 sticky set", int'(err_sticky), 1);
      do_clear();
   endtask

   task automatic t_gaps();
      clr_tally();
      beat(1'b0, 1'b0, 1'b1, 64'h0, -1);
      send_pkt(32'h4000_0004, exp_beats(32'h4000_0004), 1'b1);
      check("R8 invalid beats ignored", n_len + n_sop + n_eop, 0);
      check("R8 sticky untouched", int'(err_sticky), 0);
   endtask

   task automatic t_single();
      clr_tally();
      beat(1'b1, 1'b1, 1'b1, 64'h0, 0);
      check("R9 single beat len pulse", n_len, 1);
      check("R9 no other pulse", n_sop + n_eop, 0);
   endtask

   task automatic t_sticky();
      clr_tally();
      send_pkt(32'h0000_0000, 2, 1'b0);
      check("R10 sticky holds over good packet", int'(err_sticky), 1);
      do_clear();
      check("R10 clear drops sticky", int'(err_sticky), 0);
      sticky_clr = 1'b1;
      beat(1'b1, 1'b0, 1'b1, 64'h0, 0);
      sticky_clr = 1'b0;
      check("R10 fault beats clear", int'(err_sticky), 1);
      do_clear();
      check("R10 final clear", int'(err_sticky), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      t_good(32'h0000_0000, 2, "R3 3dw no payload");
      t_good(32'h2000_0000, 2, "R2 4dw no payload");
      t_good(32'h4000_0001, 2, "R3 3dw len1");
      t_good(32'h4000_0002, 3, "R3 3dw len2");
      t_good(32'h6000_0003, 4, "R2 4dw len3");
      t_good(32'h5000_0001, 3, "R2 message len1");
      t_good(32'h4000_0000, 514, "R1 zero length");
      t_good(32'h4000_03FF, 513, "R1 max length");
      t_early();
      t_late();
      t_sop_inside();
      t_eop_out();
      t_gaps();
      t_single();
      t_sticky();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule